// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block is the command-decoding state machine of a NOR-style flash device, limited to buffered programming. It watches single-cycle bus writes (address, data, write strobe). A valid start is two unlock writes followed by a setup write. After that it gathers address/data pairs into a 256-word staging buffer. It then waits for a confirm write and commits the staged words to a behavioural storage array. Programming can only clear bits: each committed word is ANDed into the stored word.

Two load disciplines are supported. In **counted** mode, a word count is given after setup. Loads may land anywhere in the chosen 256-word page, and a repeated address keeps its last value. In **full-page** mode, exactly 256 loads are required, with low address bytes 0x00 up to 0xFF in strict order. While an operation is busy or has ended in error, a read returns a polling status word instead of array contents. The busy period is a parameterised number of clocks.

Top module: `flashBufProgSeq`

Command codes are compared on the low data byte:

| Code | Meaning |
|------|---------|
| 0xAA | unlock 1, at address 0x555 |
| 0x55 | unlock 2, at address 0x2AA |
| 0x25 | counted setup |
| 0x33 | full-page setup |
| 0x29 | confirm |
| 0xF0 | clear error |

The page is address bits [10:8] of the setup write.

## Requirements
- R1: After reset, every array word reads 0xFFFF, and a read returns array data, not status.
- R2: Counted mode works as follows. After unlock, write 0x25 to any address in the page. The next write's low data byte is the word count minus one. Then give that many loads and a 0x29 confirm. Each loaded word is then ANDed into the array, and words that were not loaded are left unchanged.
- R3: In counted mode, every load uses up one count, including a load to an address already loaded. The value committed for a repeated address is the last one loaded.
- R4: In counted mode, a load whose address bits [10:8] differ from the setup page aborts the operation. The array is left unchanged.
- R5: Full-page mode (setup 0x33) takes 256 loads with low address bytes 0x00 through 0xFF in order, then a 0x29 confirm. It programs all 256 words of the page.
- R6: In full-page mode, a load whose low byte is not the next expected index aborts the operation. So does a load outside the page. This covers skipped, repeated and out-of-order addresses.
- R7: In either mode, a write whose data is not 0x29 arriving when the confirm is due aborts the operation. Nothing is programmed.
- R8: The abort and program-fail states persist until a write with data 0xF0. Any other write in those states is ignored. After the 0xF0 write, reads return array data again.
- R9: The status word has these bits. Bits [15:8] are 0. Bit 7 is the complement of bit 7 of the last loaded word. Bit 6 flips after every status read. Bit 5 is 1 only after a program fail. Bit 1 is 1 only after an abort. All other bits are 0.
- R10: Status is returned for exactly BUSY_CYCLES clocks after the confirm edge. If the first counted load address is not a multiple of 32, status is returned for 2*BUSY_CYCLES clocks instead.
- R11: A committed word that tries to turn a stored 0 into 1 sets status bit 5 once busy ends. The array still holds the AND of the old and new values.
- R12: If the second unlock write is wrong, the sequencer returns to idle. A later setup code and loads then have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Bus write strobe, one write per cycle |
| busRe | input | 1 | Bus read strobe |
| busAddr | input | ADDR_W (11) | Word address |
| busWdata | input | DATA_W (16) | Write data |
| busRdata | output | DATA_W (16) | Read data: array word, or status word when busy or in error |

## Verification
A write takes effect at the clock edge that ends its cycle. Read data is combinational from the resulting state, so a status or array read placed in the next cycle already shows the outcome, and the bench compares it one time step after the falling edge that drives it. For the busy window, the i-th read after the confirm edge sees the state after i further edges. The bench therefore expects status for reads 0 through BUSY_CYCLES-1 (or twice that when the start is unaligned) and array data on the read that follows. The status toggle bit is predicted by counting the bench's own status reads.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0]  CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0]  CODE_COUNTED  = 8'h25;
  localparam logic [7:0]  CODE_FULLPAGE = 8'h33;
  localparam logic [7:0]  CODE_CONFIRM  = 8'h29;
  localparam logic [7:0]  CODE_CLEAR    = 8'hF0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLOCKED1,
    ST_UNLOCKED2,
    ST_COUNT,
    ST_LOAD,
    ST_CONFIRM,
    ST_BUSY,
    ST_ABORT,
    ST_FAIL
  } seqState_t;

  typedef struct packed {
    logic bufClear;
    logic setPage;
    logic bufLoad;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        cmdByte,
  input  logic [PAGE_W-1:0] countField,
  input  logic              pageMatch,
  input  logic              progFail,
  output dpStrobe_t         strobe,
  output logic              busyFlag,
  output logic              abortFlag,
  output logic              failFlag
);

  localparam int TMR_W = $clog2(2 * BUSY_CYCLES + 1);
  localparam logic [PAGE_W-1:0] LAST_IDX = {PAGE_W{1'b1}};

  seqState_t state, stateNxt;
  logic              isFullPage;
  logic              firstLoad;
  logic              unaligned;
  logic              failLatch;
  logic [PAGE_W:0]   loadsLeft;
  logic [PAGE_W-1:0] expIdx;
  logic [TMR_W-1:0]  busyTmr;
  logic              loadOk;

  assign loadOk = pageMatch && (!isFullPage || busAddr[PAGE_W-1:0] == expIdx);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE:
        if (busWe && busAddr == ADDR_W'(UNLOCK_ADDR_A) && cmdByte == CODE_UNLOCK_A)
          stateNxt = ST_UNLOCKED1;
      ST_UNLOCKED1:
        if (busWe) begin
          if (busAddr == ADDR_W'(UNLOCK_ADDR_B) && cmdByte == CODE_UNLOCK_B)
            stateNxt = ST_UNLOCKED2;
          else
            stateNxt = ST_IDLE;
        end
      ST_UNLOCKED2:
        if (busWe) begin
          if (cmdByte == CODE_COUNTED) begin
            stateNxt        = ST_COUNT;
            strobe.setPage  = 1'b1;
            strobe.bufClear = 1'b1;
          end else if (cmdByte == CODE_FULLPAGE) begin
            stateNxt        = ST_LOAD;
            strobe.setPage  = 1'b1;
            strobe.bufClear = 1'b1;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      ST_COUNT:
        if (busWe) stateNxt = pageMatch ? ST_LOAD : ST_ABORT;
      ST_LOAD:
        if (busWe) begin
          if (!loadOk) begin
            stateNxt = ST_ABORT;
          end else begin
            strobe.bufLoad = 1'b1;
            if (isFullPage ? (expIdx == LAST_IDX) : (loadsLeft == (PAGE_W+1)'(1)))
              stateNxt = ST_CONFIRM;
          end
        end
      ST_CONFIRM:
        if (busWe) begin
          if (cmdByte == CODE_CONFIRM) begin
            stateNxt      = ST_BUSY;
            strobe.commit = 1'b1;
          end else begin
            stateNxt = ST_ABORT;
          end
        end
      ST_BUSY:
        if (busyTmr == '0) stateNxt = failLatch ? ST_FAIL : ST_IDLE;
      ST_ABORT, ST_FAIL:
        if (busWe && cmdByte == CODE_CLEAR) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      isFullPage <= 1'b0;
      firstLoad  <= 1'b0;
      unaligned  <= 1'b0;
      failLatch  <= 1'b0;
      loadsLeft  <= '0;
      expIdx     <= '0;
      busyTmr    <= '0;
    end else begin
      state <= stateNxt;
      if (strobe.setPage) begin
        isFullPage <= (cmdByte == CODE_FULLPAGE);
        firstLoad  <= 1'b1;
        unaligned  <= 1'b0;
        expIdx     <= '0;
      end
      if (state == ST_COUNT && busWe)
        loadsLeft <= {1'b0, countField} + (PAGE_W+1)'(1);
      if (strobe.bufLoad) begin
        expIdx    <= expIdx + 1'b1;
        loadsLeft <= loadsLeft - 1'b1;
        firstLoad <= 1'b0;
        if (firstLoad) unaligned <= |busAddr[4:0];
      end
      if (strobe.commit) begin
        busyTmr   <= unaligned ? TMR_W'(2 * BUSY_CYCLES - 1) : TMR_W'(BUSY_CYCLES - 1);
        failLatch <= progFail;
      end else if (state == ST_BUSY) begin
        busyTmr <= busyTmr - 1'b1;
      end
    end
  end

  assign busyFlag  = (state == ST_BUSY);
  assign abortFlag = (state == ST_ABORT);
  assign failFlag  = (state == ST_FAIL);

  // Checker state: length of the current busy run
  logic [TMR_W:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= (state == ST_BUSY) ? busyRun + 1'b1 : '0;
  end

  a_r10_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= (TMR_W+1)'(2 * BUSY_CYCLES));

  a_r4_page_escape_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && busWe && !pageMatch) |=> (state == ST_ABORT));

  a_r6_order_break_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && isFullPage && busWe && busAddr[PAGE_W-1:0] != expIdx) |=> (state == ST_ABORT));

  a_r7_bad_confirm_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIRM && busWe && cmdByte != CODE_CONFIRM) |=> (state == ST_ABORT));

  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ABORT || state == ST_FAIL) && !(busWe && cmdByte == CODE_CLEAR)) |=> $stable(state));

  a_r12_bad_unlock_idles: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UNLOCKED1 && busWe && cmdByte != CODE_UNLOCK_B) |=> (state == ST_IDLE));

  a_r9_one_status_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busyFlag, abortFlag, failFlag}));

endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  input  logic              busyFlag,
  input  logic              abortFlag,
  input  logic              failFlag,
  output logic              pageMatch,
  output logic              progFail,
  output logic [DATA_W-1:0] busRdata
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int BUF_DEPTH = 1 << PAGE_W;
  localparam int PAGE_HI_W = ADDR_W - PAGE_W;

  logic [DATA_W-1:0]    memArr  [DEPTH];
  logic [DATA_W-1:0]    bufData [BUF_DEPTH];
  logic [BUF_DEPTH-1:0] bufValid;
  logic [PAGE_HI_W-1:0] pageReg;
  logic [DATA_W-1:0]    lastWord;
  logic                 togBit;
  logic                 statusMode;

  assign statusMode = busyFlag | abortFlag | failFlag;
  assign pageMatch  = (busAddr[ADDR_W-1:PAGE_W] == pageReg);

  // Staging buffer
  always_ff @(posedge clk) begin
    if (strobe.bufLoad) bufData[busAddr[PAGE_W-1:0]] <= busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= '0;
      pageReg  <= '0;
      lastWord <= '0;
    end else begin
      if (strobe.bufClear) bufValid <= '0;
      if (strobe.setPage)  pageReg  <= busAddr[ADDR_W-1:PAGE_W];
      if (strobe.bufLoad) begin
        bufValid[busAddr[PAGE_W-1:0]] <= 1'b1;
        lastWord <= busWdata;
      end
    end
  end

  // Zero-to-one attempt detection over staged words
  always_comb begin
    progFail = 1'b0;
    for (int i = 0; i < BUF_DEPTH; i++) begin
      if (bufValid[i] && |(bufData[i] & ~memArr[{pageReg, PAGE_W'(i)}]))
        progFail = 1'b1;
    end
  end

  // Storage array: commit clears bits only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
    end else if (strobe.commit) begin
      for (int i = 0; i < BUF_DEPTH; i++) begin
        if (bufValid[i])
          memArr[{pageReg, PAGE_W'(i)}] <= memArr[{pageReg, PAGE_W'(i)}] & bufData[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    togBit <= 1'b0;
    else if (statusMode && busRe) togBit <= ~togBit;
  end

  always_comb begin
    if (statusMode) begin
      busRdata    = '0;
      busRdata[7] = ~lastWord[7];
      busRdata[6] = togBit;
      busRdata[5] = failFlag;
      busRdata[1] = abortFlag;
    end else begin
      busRdata = memArr[busAddr];
    end
  end

  a_r9_toggle_per_read: assert property (@(posedge clk) disable iff (!rstN)
    (statusMode && busRe) ##1 (statusMode && busRe) |-> busRdata[6] != $past(busRdata[6]));

  a_r9_upper_byte_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusMode |-> busRdata[DATA_W-1:8] == '0);

  a_r11_fail_flag_visible: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> busRdata[5] && !busRdata[1]);

endmodule

// File: rtl/flashBufProgSeq.sv
module flashBufProgSeq
  import flashSeqPkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  dpStrobe_t strobe;
  logic pageMatch, progFail, busyFlag, abortFlag, failFlag;

  flashSeqCtrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .cmdByte(busWdata[7:0]), .countField(busWdata[PAGE_W-1:0]),
    .pageMatch(pageMatch), .progFail(progFail), .strobe(strobe),
    .busyFlag(busyFlag), .abortFlag(abortFlag), .failFlag(failFlag)
  );

  flashSeqData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .busRe(busRe), .busyFlag(busyFlag),
    .abortFlag(abortFlag), .failFlag(failFlag), .pageMatch(pageMatch),
    .progFail(progFail), .busRdata(busRdata)
  );

endmodule

// File: tb/flashBufProgSeq_bench.sv
module flashBufProgSeq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 16;
  localparam logic [10:0] PROBE = 11'h7F0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [10:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;

  int compared = 0;
  int mismatched = 0;
  bit expTog = 1'b0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [10:0] addrQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flashBufProgSeq u_flashBufProgSeq (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busRe = 1'b0; busAddr = a; busWdata = d;
  endtask

  task automatic rdExp(input logic [10:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b1; busAddr = a;
    expQ.push_back(e); tagQ.push_back(tag); addrQ.push_back(a);
  endtask

  task automatic rdStat(input bit dq7, input bit dq5, input bit dq1, input string tag);
    logic [15:0] e;
    e = {8'h00, dq7, expTog, dq5, 3'b000, dq1, 1'b0};
    expTog = ~expTog;
    rdExp(PROBE, e, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0;
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic busyReads(input int len, input bit dq7, input string tag);
    for (int i = 0; i < len; i++) rdStat(dq7, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares each read one step after the driving falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (busRe && expQ.size() > 0) begin
        logic [15:0] e;
        string t;
        logic [10:0] a;
        e = expQ.pop_front(); t = tagQ.pop_front(); a = addrQ.pop_front();
        compared++;
        if (busRdata !== e) begin
          mismatched++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, a, busRdata, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: erased array after reset
    rdExp(11'h000, 16'hFFFF, "R1");
    rdExp(11'h7FF, 16'hFFFF, "R1");

    // R2 + R9 + R10: counted, 4 words, aligned start
    unlock();
    wr(11'h100, 16'h0025);
    wr(11'h100, 16'h0003);
    wr(11'h100, 16'h1234);
    wr(11'h101, 16'hABCD);
    wr(11'h102, 16'h00FF);
    wr(11'h103, 16'h8000);
    wr(11'h100, 16'h0029);
    busyReads(BUSY, 1'b1, "R10_aligned_R9");
    rdExp(PROBE, 16'hFFFF, "R10_aligned_end");
    rdExp(11'h100, 16'h1234, "R2");
    rdExp(11'h101, 16'hABCD, "R2");
    rdExp(11'h102, 16'h00FF, "R2");
    rdExp(11'h103, 16'h8000, "R2");
    rdExp(11'h104, 16'hFFFF, "R2_untouched");

    // R3 + R10: counted with repeat, unaligned start doubles busy
    unlock();
    wr(11'h200, 16'h0025);
    wr(11'h200, 16'h0002);
    wr(11'h205, 16'h1111);
    wr(11'h206, 16'h2222);
    wr(11'h205, 16'h3333);
    wr(11'h200, 16'h0029);
    busyReads(2 * BUSY, 1'b1, "R10_unaligned");
    rdExp(PROBE, 16'hFFFF, "R10_unaligned_end");
    rdExp(11'h205, 16'h3333, "R3");
    rdExp(11'h206, 16'h2222, "R3");
    rdExp(11'h207, 16'hFFFF, "R3");

    // R4 + R8: out-of-page load aborts, sticky until clear
    unlock();
    wr(11'h300, 16'h0025);
    wr(11'h300, 16'h0001);
    wr(11'h300, 16'h0000);
    wr(11'h410, 16'h0000);
    rdStat(1'b1, 1'b0, 1'b1, "R4");
    wr(11'h300, 16'h0029);
    rdStat(1'b1, 1'b0, 1'b1, "R8");
    wr(11'h000, 16'h00F0);
    rdExp(11'h300, 16'hFFFF, "R4_R8");

    // R12: broken unlock has no effect
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0012);
    wr(11'h300, 16'h0025);
    wr(11'h300, 16'h0000);
    wr(11'h300, 16'h0000);
    wr(11'h300, 16'h0029);
    rdExp(11'h300, 16'hFFFF, "R12");

    // R5: full page
    unlock();
    wr(11'h4A0, 16'h0033);
    for (int i = 0; i < 256; i++)
      wr({3'd4, 8'(i)}, {8'(i) ^ 8'hC3, 8'(i)});
    wr(11'h400, 16'h0029);
    busyReads(BUSY, 1'b0, "R5_busy");
    rdExp(PROBE, 16'hFFFF, "R5_end");
    rdExp(11'h400, 16'hC300, "R5");
    rdExp(11'h47F, 16'hBC7F, "R5");
    rdExp(11'h4FF, 16'h3CFF, "R5");

    // R6: skipped index aborts
    unlock();
    wr(11'h600, 16'h0033);
    wr(11'h600, 16'h0000);
    wr(11'h601, 16'h0000);
    wr(11'h603, 16'h0000);
    rdStat(1'b1, 1'b0, 1'b1, "R6");
    wr(11'h000, 16'h00F0);
    rdExp(11'h600, 16'hFFFF, "R6");

    // R7: wrong confirm aborts
    unlock();
    wr(11'h700, 16'h0025);
    wr(11'h700, 16'h0000);
    wr(11'h700, 16'h0F0F);
    wr(11'h700, 16'h0030);
    rdStat(1'b1, 1'b0, 1'b1, "R7");
    wr(11'h000, 16'h00F0);
    rdExp(11'h700, 16'hFFFF, "R7");

    // R11: 0->1 attempt flags fail, array holds AND
    unlock();
    wr(11'h100, 16'h0025);
    wr(11'h100, 16'h0000);
    wr(11'h100, 16'h1235);
    wr(11'h100, 16'h0029);
    busyReads(BUSY, 1'b1, "R11_busy");
    rdStat(1'b1, 1'b1, 1'b0, "R11");
    wr(11'h000, 16'h00F0);
    rdExp(11'h100, 16'h1234, "R11");

    idle();
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL queue: actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule